// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers the chip's internal reset causes (watchdog expiry, illegal instruction, instruction fetch from an unmapped address, and supply brown-out), records in a latched status word which causes have fired, and pulls the active-low external reset pad low through an open-drain style drive enable. Once the last reset request has gone away, a reference-clock counter keeps the pad driven for a fixed hold time. A second, shorter count then keeps the processor core in reset so that the reset pad has settled before the vector fetch begins.

Two option inputs shape the decode. A stop-enable option decides whether a STOP instruction is legal or counts as an illegal instruction. Two brown-out options, a power-down option and a reset-disable option, can stop a brown-out from driving the pad while still letting its status bit be recorded. Software reads the status word through a read strobe, and the read clears the word. A power-on reset clears the status, drives the pad and holds the core in reset.

Top module: `rst_sequencer`

## Requirements
- R1: Any reset request sampled on a clock edge drives `pad_pull_low` high and `core_rst_n` low from that edge onward. The reset requests are `wdt_expire`, `cpu_bad_op`, a STOP counted as illegal, an unmapped instruction fetch, and brown-out when neither brown-out option is set.
- R2: `cpu_bad_op` sets status bit 1 (illegal instruction) and causes a reset.
- R3: `cpu_stop_op` with `opt_stop_en` = 0 counts as an illegal instruction (status bit 1 and a reset). With `opt_stop_en` = 1 it has no effect on the pad or the status.
- R4: `addr_unmapped` together with `cpu_ifetch` = 1 sets status bit 2 (illegal address) and causes a reset. With `cpu_ifetch` = 0 it has no effect.
- R5: `wdt_expire` sets status bit 0 (watchdog) and causes a reset.
- R6: `lv_low` always sets status bit 3 (brown-out). It causes a reset only when `opt_lv_pwrdn` and `opt_lv_rst_dis` are both 0.
- R7: The pad is driven for exactly PIN_HOLD cycles (default 4096+32 = 4128) after the last edge on which a request was sampled.
- R8: `core_rst_n` rises exactly CPU_GAP cycles (default 32) after the pad is released, and it is never high while the pad is driven.
- R9: A request that arrives while the hold count is running restarts the count from zero.
- R10: Status bits stay set until a cycle with `stat_rd` = 1 and no new request, after which `stat_q` reads 0. While `por_n` = 0 the status is 0, the pad is driven and the core is held in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wdt_expire | input | 1 | Watchdog timeout request |
| cpu_ifetch | input | 1 | Core is fetching an instruction this cycle |
| cpu_bad_op | input | 1 | Core decoded an illegal instruction |
| cpu_stop_op | input | 1 | Core decoded a STOP instruction |
| addr_unmapped | input | 1 | Current access hits no mapped region |
| opt_stop_en | input | 1 | Option: STOP instruction allowed |
| opt_lv_pwrdn | input | 1 | Option: brown-out detector powered down |
| opt_lv_rst_dis | input | 1 | Option: brown-out reset disabled |
| lv_low | input | 1 | Supply below the brown-out threshold |
| stat_rd | input | 1 | Status read strobe (clears status) |
| stat_q | output | 4 | Status: bit0 watchdog, bit1 illegal op, bit2 illegal address, bit3 brown-out |
| pad_pull_low | output | 1 | Drive enable that pulls the reset pad low |
| core_rst_n | output | 1 | Core reset, active low |

## Verification
The checker assumes that the request inputs are synchronous to `clk_ref` and stable around its rising edge. It also assumes that a status read carries no meaning beyond clearing. The stimulus changes every input only on the falling edge and pulses each cause for a single cycle, except brown-out, which is held for several cycles. Reads are issued only when no request is active, so the clear is never in contention with a set.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

   localparam int unsigned NUM_SRC = 4;

   localparam int unsigned SRC_WDT  = 0;
   localparam int unsigned SRC_OP   = 1;
   localparam int unsigned SRC_ADDR = 2;
   localparam int unsigned SRC_LV   = 3;

   typedef enum logic [1:0] {
      ST_PAD  = 2'd0,
      ST_CORE = 2'd1,
      ST_RUN  = 2'd2
   } seq_state_e;

endpackage

// File: rtl/rstseq_src_decode.sv
module rstseq_src_decode
   import rstseq_pkg::*;
(
   input  logic               wdt_expire,
   input  logic               cpu_ifetch,
   input  logic               cpu_bad_op,
   input  logic               cpu_stop_op,
   input  logic               addr_unmapped,
   input  logic               opt_stop_en,
   input  logic               opt_lv_pwrdn,
   input  logic               opt_lv_rst_dis,
   input  logic               lv_low,
   output logic [NUM_SRC-1:0] src_flag,
   output logic               any_req
);

   logic lv_reset_en;

   always_comb begin
      src_flag           = '0;
      src_flag[SRC_WDT]  = wdt_expire;
      src_flag[SRC_OP]   = cpu_bad_op | (cpu_stop_op & ~opt_stop_en);
      src_flag[SRC_ADDR] = addr_unmapped & cpu_ifetch;
      src_flag[SRC_LV]   = lv_low;
   end

   assign lv_reset_en = ~(opt_lv_pwrdn | opt_lv_rst_dis);

   assign any_req = src_flag[SRC_WDT] | src_flag[SRC_OP] | src_flag[SRC_ADDR]
                  | (src_flag[SRC_LV] & lv_reset_en);

endmodule

// File: rtl/rstseq_hold_timer.sv
module rstseq_hold_timer
   import rstseq_pkg::*;
#(
   parameter int unsigned PIN_HOLD = 4128,
   parameter int unsigned CPU_GAP  = 32
) (
   input  logic clk_ref,
   input  logic por_n,
   input  logic any_req,
   output logic pad_pull_low,
   output logic core_rst_n
);

   localparam int unsigned MAX_CNT = (PIN_HOLD > CPU_GAP) ? PIN_HOLD : CPU_GAP;
   localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
   localparam logic [CNT_W-1:0] PAD_LAST  = CNT_W'(PIN_HOLD - 1);
   localparam logic [CNT_W-1:0] CORE_LAST = CNT_W'(CPU_GAP - 1);

   seq_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_ref or negedge por_n) begin
      if (!por_n) begin
         st_q  <= ST_PAD;
         cnt_q <= '0;
      end else if (any_req) begin
         st_q  <= ST_PAD;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            ST_PAD: begin
               if (cnt_q == PAD_LAST) begin
                  st_q  <= ST_CORE;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_CORE: begin
               if (cnt_q == CORE_LAST) begin
                  st_q  <= ST_RUN;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               st_q  <= ST_RUN;
               cnt_q <= '0;
            end
         endcase
      end
   end

   assign pad_pull_low = (st_q == ST_PAD);
   assign core_rst_n   = (st_q == ST_RUN);

endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
   import rstseq_pkg::*;
(
   input  logic               clk_ref,
   input  logic               por_n,
   input  logic [NUM_SRC-1:0] src_flag,
   input  logic               stat_rd,
   output logic [NUM_SRC-1:0] stat_q
);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk_ref or negedge por_n) begin
         if (!por_n)           stat_q[i] <= 1'b0;
         else if (src_flag[i]) stat_q[i] <= 1'b1;
         else if (stat_rd)     stat_q[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
   import rstseq_pkg::*;
#(
   parameter int unsigned PIN_HOLD = 4096 + 32,
   parameter int unsigned CPU_GAP  = 32
) (
   input  logic               clk_ref,
   input  logic               por_n,
   input  logic               wdt_expire,
   input  logic               cpu_ifetch,
   input  logic               cpu_bad_op,
   input  logic               cpu_stop_op,
   input  logic               addr_unmapped,
   input  logic               opt_stop_en,
   input  logic               opt_lv_pwrdn,
   input  logic               opt_lv_rst_dis,
   input  logic               lv_low,
   input  logic               stat_rd,
   output logic [NUM_SRC-1:0] stat_q,
   output logic               pad_pull_low,
   output logic               core_rst_n
);

   if (PIN_HOLD < 2) begin : g_bad_hold
      $error("rst_sequencer: PIN_HOLD must be at least 2");
   end
   if (CPU_GAP < 1) begin : g_bad_gap
      $error("rst_sequencer: CPU_GAP must be at least 1");
   end

   logic [NUM_SRC-1:0] src_flag;
   logic               any_req;

   rstseq_src_decode u_decode (
      .wdt_expire     (wdt_expire),
      .cpu_ifetch     (cpu_ifetch),
      .cpu_bad_op     (cpu_bad_op),
      .cpu_stop_op    (cpu_stop_op),
      .addr_unmapped  (addr_unmapped),
      .opt_stop_en    (opt_stop_en),
      .opt_lv_pwrdn   (opt_lv_pwrdn),
      .opt_lv_rst_dis (opt_lv_rst_dis),
      .lv_low         (lv_low),
      .src_flag       (src_flag),
      .any_req        (any_req)
   );

   rstseq_hold_timer #(
      .PIN_HOLD (PIN_HOLD),
      .CPU_GAP  (CPU_GAP)
   ) u_timer (
      .clk_ref      (clk_ref),
      .por_n        (por_n),
      .any_req      (any_req),
      .pad_pull_low (pad_pull_low),
      .core_rst_n   (core_rst_n)
   );

   rstseq_status u_status (
      .clk_ref  (clk_ref),
      .por_n    (por_n),
      .src_flag (src_flag),
      .stat_rd  (stat_rd),
      .stat_q   (stat_q)
   );

endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker (
   input logic       clk_ref,
   input logic       por_n,
   input logic       wdt_expire,
   input logic       cpu_ifetch,
   input logic       cpu_bad_op,
   input logic       cpu_stop_op,
   input logic       addr_unmapped,
   input logic       opt_stop_en,
   input logic       lv_low,
   input logic       stat_rd,
   input logic [3:0] stat_q,
   input logic       pad_pull_low,
   input logic       core_rst_n
);

   AST_WDT_PULLS_PAD: assert property (@(posedge clk_ref) disable iff (!por_n)
      wdt_expire |=> (pad_pull_low && !core_rst_n));                          // R1

   AST_BADOP_SETS_BIT: assert property (@(posedge clk_ref) disable iff (!por_n)
      cpu_bad_op |=> stat_q[1]);                                              // R2

   AST_OP_BIT_CAUSE: assert property (@(posedge clk_ref) disable iff (!por_n)
      $rose(stat_q[1]) |-> $past(cpu_bad_op || (cpu_stop_op && !opt_stop_en))); // R3

   AST_ADDR_BIT_CAUSE: assert property (@(posedge clk_ref) disable iff (!por_n)
      $rose(stat_q[2]) |-> $past(addr_unmapped && cpu_ifetch));               // R4

   AST_WDT_SETS_BIT: assert property (@(posedge clk_ref) disable iff (!por_n)
      wdt_expire |=> stat_q[0]);                                              // R5

   AST_LV_SETS_BIT: assert property (@(posedge clk_ref) disable iff (!por_n)
      lv_low |=> stat_q[3]);                                                  // R6

   AST_CORE_AFTER_PAD: assert property (@(posedge clk_ref) disable iff (!por_n)
      pad_pull_low |-> !core_rst_n);                                          // R8

   AST_READ_CLEARS: assert property (@(posedge clk_ref) disable iff (!por_n)
      (stat_rd && !wdt_expire && !cpu_bad_op && !cpu_stop_op
       && !addr_unmapped && !lv_low) |=> (stat_q == 4'b0000));                // R10

endmodule

bind rst_sequencer rstseq_checker u_rstseq_checker (
   .clk_ref       (clk_ref),
   .por_n         (por_n),
   .wdt_expire    (wdt_expire),
   .cpu_ifetch    (cpu_ifetch),
   .cpu_bad_op    (cpu_bad_op),
   .cpu_stop_op   (cpu_stop_op),
   .addr_unmapped (addr_unmapped),
   .opt_stop_en   (opt_stop_en),
   .lv_low        (lv_low),
   .stat_rd       (stat_rd),
   .stat_q        (stat_q),
   .pad_pull_low  (pad_pull_low),
   .core_rst_n    (core_rst_n)
);

// File: tb/test_rst_sequencer.sv
module test_rst_sequencer;

   localparam int PIN_HOLD = 4128;
   localparam int CPU_GAP  = 32;

   logic       clk_ref = 1'b0;
   logic       por_n = 1'b0;
   logic       wdt_expire = 1'b0, cpu_ifetch = 1'b0, cpu_bad_op = 1'b0;
   logic       cpu_stop_op = 1'b0, addr_unmapped = 1'b0, opt_stop_en = 1'b0;
   logic       opt_lv_pwrdn = 1'b0, opt_lv_rst_dis = 1'b0, lv_low = 1'b0;
   logic       stat_rd = 1'b0;
   logic [3:0] stat_q;
   logic       pad_pull_low, core_rst_n;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always #5 clk_ref = ~clk_ref;

   rst_sequencer i_rst_sequencer (
      .clk_ref(clk_ref), .por_n(por_n), .wdt_expire(wdt_expire),
      .cpu_ifetch(cpu_ifetch), .cpu_bad_op(cpu_bad_op), .cpu_stop_op(cpu_stop_op),
      .addr_unmapped(addr_unmapped), .opt_stop_en(opt_stop_en),
      .opt_lv_pwrdn(opt_lv_pwrdn), .opt_lv_rst_dis(opt_lv_rst_dis),
      .lv_low(lv_low), .stat_rd(stat_rd), .stat_q(stat_q),
      .pad_pull_low(pad_pull_low), .core_rst_n(core_rst_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   always @(posedge clk_ref) begin
      cyc <= cyc + 1;
      if (cyc > 190000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
         finish_run();
      end
   end

   // Count pad-driven cycles, then core-held cycles, sampled on falling edges.
   task automatic measure(output int pad_cyc, output int core_cyc);
      pad_cyc  = 0;
      core_cyc = 0;
      while (pad_pull_low && pad_cyc < 20000) begin
         pad_cyc++;
         @(negedge clk_ref);
      end
      while (!core_rst_n && core_cyc < 20000) begin
         core_cyc++;
         @(negedge clk_ref);
      end
   endtask

   task automatic read_clear();
      stat_rd = 1'b1;
      @(negedge clk_ref);
      stat_rd = 1'b0;
      check(stat_q == 4'b0000, "R10 read clears", stat_q, 0);
   endtask

   task automatic t_power_on();
      repeat (3) @(negedge clk_ref);
      check(pad_pull_low == 1'b1, "R10 por pad", pad_pull_low, 1);
      check(core_rst_n == 1'b0, "R10 por core", core_rst_n, 0);
      check(stat_q == 4'b0000, "R10 por status", stat_q, 0);
      por_n = 1'b1;
      while (!core_rst_n) @(negedge clk_ref);
      check(stat_q == 4'b0000, "R10 status after por", stat_q, 0);
   endtask

   task automatic t_watchdog();
      int p, c;
      wdt_expire = 1'b1;
      @(negedge clk_ref);
      wdt_expire = 1'b0;
      check(pad_pull_low && !core_rst_n, "R1 wdt pulls pad", pad_pull_low, 1);
      measure(p, c);
      check(p == PIN_HOLD, "R7 pad hold", p, PIN_HOLD);
      check(c == CPU_GAP, "R8 core gap", c, CPU_GAP);
      check(stat_q == 4'b0001, "R5 wdt status", stat_q, 1);
      read_clear();
   endtask

   task automatic t_bad_op();
      int p, c;
      cpu_bad_op = 1'b1;
      @(negedge clk_ref);
      cpu_bad_op = 1'b0;
      check(pad_pull_low == 1'b1, "R2 bad op reset", pad_pull_low, 1);
      measure(p, c);
      check(p == PIN_HOLD, "R7 pad hold bad op", p, PIN_HOLD);
      check(stat_q == 4'b0010, "R2 bad op status", stat_q, 2);
      read_clear();
   endtask

   task automatic t_stop();
      int p, c;
      opt_stop_en = 1'b1;
      cpu_stop_op = 1'b1;
      @(negedge clk_ref);
      cpu_stop_op = 1'b0;
      check(pad_pull_low == 1'b0, "R3 legal stop pad", pad_pull_low, 0);
      check(stat_q == 4'b0000, "R3 legal stop status", stat_q, 0);
      opt_stop_en = 1'b0;
      cpu_stop_op = 1'b1;
      @(negedge clk_ref);
      cpu_stop_op = 1'b0;
      check(pad_pull_low == 1'b1, "R3 illegal stop pad", pad_pull_low, 1);
      measure(p, c);
      check(stat_q == 4'b0010, "R3 illegal stop status", stat_q, 2);
      read_clear();
   endtask

   task automatic t_addr();
      int p, c;
      addr_unmapped = 1'b1;
      cpu_ifetch    = 1'b0;
      @(negedge clk_ref);
      addr_unmapped = 1'b0;
      check(pad_pull_low == 1'b0, "R4 data access pad", pad_pull_low, 0);
      check(stat_q == 4'b0000, "R4 data access status", stat_q, 0);
      addr_unmapped = 1'b1;
      cpu_ifetch    = 1'b1;
      @(negedge clk_ref);
      addr_unmapped = 1'b0;
      cpu_ifetch    = 1'b0;
      check(pad_pull_low == 1'b1, "R4 fetch pad", pad_pull_low, 1);
      measure(p, c);
      check(p == PIN_HOLD, "R7 pad hold addr", p, PIN_HOLD);
      check(stat_q == 4'b0100, "R4 fetch status", stat_q, 4);
      // latch: a second cause adds its bit without a read
      wdt_expire = 1'b1;
      @(negedge clk_ref);
      wdt_expire = 1'b0;
      measure(p, c);
      check(stat_q == 4'b0101, "R10 bits latched", stat_q, 5);
      read_clear();
   endtask

   task automatic t_low_voltage();
      int p, c;
      lv_low = 1'b1;
      repeat (10) @(negedge clk_ref);
      lv_low = 1'b0;
      check(pad_pull_low == 1'b1, "R6 lv pad", pad_pull_low, 1);
      measure(p, c);
      check(p == PIN_HOLD, "R7 lv hold after recovery", p, PIN_HOLD);
      check(c == CPU_GAP, "R8 lv core gap", c, CPU_GAP);
      check(stat_q == 4'b1000, "R6 lv status", stat_q, 8);
      read_clear();
      for (int k = 0; k < 2; k++) begin
         opt_lv_pwrdn   = (k == 0);
         opt_lv_rst_dis = (k == 1);
         lv_low = 1'b1;
         repeat (4) @(negedge clk_ref);
         lv_low = 1'b0;
         check(pad_pull_low == 1'b0 && core_rst_n == 1'b1, "R6 lv option no reset",
               pad_pull_low, 0);
         check(stat_q == 4'b1000, "R6 lv option status", stat_q, 8);
         read_clear();
      end
      opt_lv_pwrdn   = 1'b0;
      opt_lv_rst_dis = 1'b0;
   endtask

   task automatic t_restart();
      int p, c;
      wdt_expire = 1'b1;
      @(negedge clk_ref);
      wdt_expire = 1'b0;
      repeat (100) @(negedge clk_ref);
      cpu_bad_op = 1'b1;
      @(negedge clk_ref);
      cpu_bad_op = 1'b0;
      measure(p, c);
      check(p == PIN_HOLD, "R9 restart hold", p, PIN_HOLD);
      check(c == CPU_GAP, "R9 restart gap", c, CPU_GAP);
      read_clear();
   endtask

   initial begin
      @(negedge clk_ref);
      t_power_on();
      t_watchdog();
      t_bad_op();
      t_stop();
      t_addr();
      t_low_voltage();
      t_restart();
      finish_run();
   end

endmodule